// File: doc/BRIEF.md
# Two-Level Page Table Walker

This engine resolves a 32-bit virtual address after the translation cache has missed. It takes one request at a time, reads page table entries over a single-outstanding memory read port, and either hands back a refill result (physical page number, attribute bits, page size and full physical address) or signals a page fault. The walk starts from a table base that the core supplies together with each request.

A virtual address is split into a first-level index (bits 31:22), a second-level index (bits 21:12) and a 12-bit offset. Entries are 4 bytes wide, so each entry address is a table base plus the index times four. A first-level entry either points to a second-level table or maps a 4 MB page directly. In the second case the walk ends after one read. A non-present entry at either level ends the walk with a fault that reports the level.

Entry layout: bit 0 is the present flag, bit 1 is the large-page flag (meaningful only at the first level), bits 11:2 are attribute bits passed through to the refill, and bits 31:12 are the frame number.

Top module: `page_walker`

## Requirements
- R1: After reset `req_ready_o` is 1 and `mem_req_valid_o`, `done_o` and `fault_o` are all 0.
- R2: The first read of a walk goes to `root_base_i` (as captured when the request was accepted) plus `req_va_i[31:22]` times 4.
- R3: A first-level entry with bit 0 clear ends the walk with a one-cycle `fault_o` and `fault_level_o` = 0, and no second read is issued.
- R4: A first-level entry with bits 0 and 1 set ends the walk with `done_o` and `res_large_o` = 1, `res_ppn_o` = {entry[31:22], va[21:12]}, `res_pa_o` = {entry[31:22], va[21:0]}, and no second read is issued.
- R5: For a present first-level entry with bit 1 clear, the second read goes to {entry[31:12], 12'h000} plus va[21:12] times 4.
- R6: A second-level entry with bit 0 clear ends the walk with a one-cycle `fault_o` and `fault_level_o` = 1.
- R7: A present second-level entry ends the walk with `done_o`, `res_large_o` = 0, `res_ppn_o` = entry[31:12], `res_pa_o` = {entry[31:12], va[11:0]}. Bit 1 of a second-level entry has no effect.
- R8: Once a request is accepted, `req_ready_o` stays 0 until the cycle after the `done_o` or `fault_o` pulse. Requests offered while busy are not taken.
- R9: `mem_req_valid_o` stays high with a stable `mem_req_addr_o` until `mem_req_ready_i` is seen. A response may arrive any number of cycles later, and only one read is outstanding.
- R10: `done_o` and `fault_o` are one-cycle pulses that never occur together. `res_attr_o` carries bits 11:2 of the final entry. All result fields hold until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request offered |
| req_ready_o | output | 1 | Walker idle and able to take a request |
| req_va_i | input | 32 | Virtual address to translate |
| root_base_i | input | 32 | Physical base of the first-level table |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory takes the read request |
| mem_req_addr_o | output | 32 | Physical address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| done_o | output | 1 | One-cycle pulse: translation ready |
| fault_o | output | 1 | One-cycle pulse: page fault |
| fault_level_o | output | 1 | Level of the faulting entry (0 first, 1 second) |
| res_ppn_o | output | 20 | Physical page number for the refill |
| res_attr_o | output | 10 | Attribute bits of the final entry |
| res_large_o | output | 1 | Result maps a 4 MB page |
| res_pa_o | output | 32 | Physical address of the requested virtual address |

## Verification
A wrong state or a wrong latched base shows up first on `mem_req_addr_o`, in the cycle the read request is raised. So the bench records every read address and compares it with the index arithmetic. A walker that skips or repeats a level shows up at the end of the walk as the wrong number of reads, or as a result that ends at the wrong level, within a few cycles of the last response. Stalled request acceptance and long response latencies are mixed in, so that a state that leaves early or waits in the wrong place either issues an extra read or hangs until the bench times out.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W        = 32;
  localparam int unsigned OFF_W       = 12;
  localparam int unsigned IDX_W       = 10;
  localparam int unsigned ENTRY_SHIFT = 2;
  localparam int unsigned LVLS        = 2;
  localparam int unsigned PTE_PRESENT = 0;
  localparam int unsigned PTE_LARGE   = 1;
  localparam int unsigned ATTR_LO     = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned AW          = 32,
  parameter int unsigned IDX_W       = 10,
  parameter int unsigned ENTRY_SHIFT = 2
) (
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [AW-1:0]    addr_o
);
  logic [AW-1:0] offs;
  assign offs   = AW'(idx_i) << ENTRY_SHIFT;
  assign addr_o = base_i + offs;
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PPN_W  = PTE_W - OFF_W,
  parameter int unsigned ATTR_W = OFF_W - ptw_pkg::ATTR_LO
) (
  input  logic [PTE_W-1:0]  pte_i,
  output logic              present_o,
  output logic              large_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic [PPN_W-1:0]  frame_o
);
  assign present_o = pte_i[ptw_pkg::PTE_PRESENT];
  assign large_o   = pte_i[ptw_pkg::PTE_LARGE];
  assign attr_o    = pte_i[ptw_pkg::ATTR_LO +: ATTR_W];
  assign frame_o   = pte_i[PTE_W-1 -: PPN_W];
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_req_ready_i,
  input  logic mem_rsp_valid_i,
  input  logic pte_present_i,
  input  logic pte_large_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic mem_req_valid_o,
  output logic lvl2_o,
  output logic next_table_o,
  output logic leaf_o,
  output logic done_o,
  output logic fault_o,
  output logic fault_level_o
);
  walk_state_e state_q, state_d;
  logic        flvl_q;
  logic        rsp_l1, rsp_l2;

  assign rsp_l1 = (state_q == ST_L1_WAIT) && mem_rsp_valid_i;
  assign rsp_l2 = (state_q == ST_L2_WAIT) && mem_rsp_valid_i;

  assign req_ready_o     = (state_q == ST_IDLE);
  assign accept_o        = req_ready_o && req_valid_i;
  assign mem_req_valid_o = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign lvl2_o          = (state_q == ST_L2_REQ) || (state_q == ST_L2_WAIT);
  assign next_table_o    = rsp_l1 && pte_present_i && !pte_large_i;
  assign leaf_o          = (rsp_l1 && pte_present_i && pte_large_i) || (rsp_l2 && pte_present_i);
  assign done_o          = (state_q == ST_DONE);
  assign fault_o         = (state_q == ST_FAULT);
  assign fault_level_o   = flvl_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_req_ready_i) state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rsp_valid_i)
                    state_d = !pte_present_i ? ST_FAULT : (pte_large_i ? ST_DONE : ST_L2_REQ);
      ST_L2_REQ:  if (mem_req_ready_i) state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rsp_valid_i) state_d = pte_present_i ? ST_DONE : ST_FAULT;
      ST_DONE:    state_d = ST_IDLE;
      ST_FAULT:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flvl_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((rsp_l1 || rsp_l2) && !pte_present_i) flvl_q <= rsp_l2;
    end
  end

  assert_busy_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_ready_after_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> req_ready_o);
  assert_end_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_fault_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);
  assert_l1_fault_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_level_o) |-> $past(state_q == ST_L1_WAIT));
  assert_l2_fault_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && fault_level_o) |-> $past(state_q == ST_L2_WAIT));
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W        = ptw_pkg::VA_W,
  parameter int unsigned OFF_W       = ptw_pkg::OFF_W,
  parameter int unsigned IDX_W       = ptw_pkg::IDX_W,
  parameter int unsigned ENTRY_SHIFT = ptw_pkg::ENTRY_SHIFT,
  localparam int unsigned PPN_W      = VA_W - OFF_W,
  localparam int unsigned ATTR_W     = OFF_W - ptw_pkg::ATTR_LO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [VA_W-1:0]   root_base_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [VA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [VA_W-1:0]   mem_rsp_data_i,
  output logic              done_o,
  output logic              fault_o,
  output logic              fault_level_o,
  output logic [PPN_W-1:0]  res_ppn_o,
  output logic [ATTR_W-1:0] res_attr_o,
  output logic              res_large_o,
  output logic [VA_W-1:0]   res_pa_o
);
  logic [VA_W-1:0]   va_q, root_q;
  logic [PPN_W-1:0]  tbl_frame_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [ATTR_W-1:0] attr_q;
  logic              large_q;

  logic              accept, lvl2, next_table, leaf;
  logic              pte_present, pte_large;
  logic [ATTR_W-1:0] pte_attr;
  logic [PPN_W-1:0]  pte_frame;

  logic [VA_W-1:0]   lvl_base [LVLS];
  logic [VA_W-1:0]   lvl_addr [LVLS];

  assign lvl_base[0] = root_q;
  assign lvl_base[1] = {tbl_frame_q, {OFF_W{1'b0}}};

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    ptw_addr_gen #(
      .AW(VA_W), .IDX_W(IDX_W), .ENTRY_SHIFT(ENTRY_SHIFT)
    ) u_addr (
      .base_i (lvl_base[g]),
      .idx_i  (va_q[VA_W-1-g*IDX_W -: IDX_W]),
      .addr_o (lvl_addr[g])
    );
  end

  assign mem_req_addr_o = lvl2 ? lvl_addr[1] : lvl_addr[0];

  ptw_pte_decode #(.PTE_W(VA_W), .OFF_W(OFF_W)) u_dec (
    .pte_i     (mem_rsp_data_i),
    .present_o (pte_present),
    .large_o   (pte_large),
    .attr_o    (pte_attr),
    .frame_o   (pte_frame)
  );

  ptw_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .pte_present_i   (pte_present),
    .pte_large_i     (pte_large),
    .req_ready_o     (req_ready_o),
    .accept_o        (accept),
    .mem_req_valid_o (mem_req_valid_o),
    .lvl2_o          (lvl2),
    .next_table_o    (next_table),
    .leaf_o          (leaf),
    .done_o          (done_o),
    .fault_o         (fault_o),
    .fault_level_o   (fault_level_o)
  );

  // large page keeps the second-level index bits from the virtual address
  logic [PPN_W-1:0] leaf_ppn;
  assign leaf_ppn = lvl2 ? pte_frame
                         : {pte_frame[PPN_W-1:IDX_W], va_q[OFF_W+IDX_W-1:OFF_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q        <= '0;
      root_q      <= '0;
      tbl_frame_q <= '0;
      ppn_q       <= '0;
      attr_q      <= '0;
      large_q     <= 1'b0;
    end else begin
      if (accept) begin
        va_q   <= req_va_i;
        root_q <= root_base_i;
      end
      if (next_table) tbl_frame_q <= pte_frame;
      if (leaf) begin
        ppn_q   <= leaf_ppn;
        attr_q  <= pte_attr;
        large_q <= !lvl2;
      end
    end
  end

  assign res_ppn_o   = ppn_q;
  assign res_attr_o  = attr_q;
  assign res_large_o = large_q;
  assign res_pa_o    = {ppn_q, va_q[OFF_W-1:0]};

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
  assert_large_from_l1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && res_large_o) |-> $past(!lvl2));
  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_valid_i) |=> $stable(res_ppn_o) && $stable(res_attr_o));
endmodule

// File: tb/sim_page_walker.sv
module sim_page_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_va_i = '0;
  logic [31:0] root_base_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        done_o, fault_o, fault_level_o;
  logic [19:0] res_ppn_o;
  logic [9:0]  res_attr_o;
  logic        res_large_o;
  logic [31:0] res_pa_o;

  page_walker u0 (.*);

  always #4 clk_i = ~clk_i;

  int n_checks = 0;
  int n_fail   = 0;

  // memory model
  logic [31:0] pt_mem [logic [31:0]];
  logic [31:0] reads [8];
  int          n_reads   = 0;
  int          rsp_lat   = 1;
  int          ready_gap = 0;
  int          rsp_cnt   = 0;
  int          stall_ctr = 0;
  logic [31:0] rd_data   = '0;

  always @(negedge clk_i) begin
    mem_rsp_valid_i = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = rd_data;
      end
    end
    stall_ctr++;
    mem_req_ready_i = ((stall_ctr % (ready_gap + 1)) == 0);
    if (rst_ni && mem_req_valid_o && mem_req_ready_i) begin
      if (n_reads < 8) reads[n_reads] = mem_req_addr_o;
      n_reads++;
      rd_data = pt_mem.exists(mem_req_addr_o) ? pt_mem[mem_req_addr_o] : 32'h0;
      rsp_cnt = rsp_lat;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] l1_addr(logic [31:0] root, logic [31:0] va);
    return root + (32'(va[31:22]) << 2);
  endfunction

  function automatic logic [31:0] l2_addr(logic [31:0] pte1, logic [31:0] va);
    return {pte1[31:12], 12'h000} + (32'(va[21:12]) << 2);
  endfunction

  task automatic issue(logic [31:0] root, logic [31:0] va);
    n_reads = 0;
    @(negedge clk_i);
    root_base_i = root;
    req_va_i    = va;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    root_base_i = 32'hdead_0000;
  endtask

  task automatic wait_end(output bit got_done, output bit got_fault);
    got_done = 0;
    got_fault = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      if (done_o || fault_o) begin
        got_done  = done_o;
        got_fault = fault_o;
        break;
      end
    end
  endtask

  task automatic test_reset();
    chk("R1 req_ready", 32'(req_ready_o), 32'd1);
    chk("R1 mem_req_valid", 32'(mem_req_valid_o), 32'd0);
    chk("R1 done/fault", {30'd0, done_o, fault_o}, 32'd0);
  endtask

  task automatic test_small_page();
    logic [31:0] root = 32'h0010_0000, va = 32'h1234_5678;
    logic [31:0] pte1 = 32'h0020_0001;
    logic [31:0] pte2 = 32'habcd_e000 | 32'h0000_0ab7;  // attrs, bit1 set (ignored)
    bit d, f;
    pt_mem[l1_addr(root, va)] = pte1;
    pt_mem[l2_addr(pte1, va)] = pte2;
    rsp_lat = 3; ready_gap = 0;
    issue(root, va);
    wait_end(d, f);
    chk("R7 done", {30'd0, d, f}, 32'd2);
    chk("R2 l1 addr", reads[0], l1_addr(root, va));
    chk("R5 l2 addr", reads[1], l2_addr(pte1, va));
    chk("R7 reads", 32'(n_reads), 32'd2);
    chk("R7 ppn", 32'(res_ppn_o), 32'(pte2[31:12]));
    chk("R7 pa", res_pa_o, {pte2[31:12], va[11:0]});
    chk("R7 large ignored at l2", 32'(res_large_o), 32'd0);
    chk("R10 attr", 32'(res_attr_o), 32'(pte2[11:2]));
  endtask

  task automatic test_large_page();
    logic [31:0] root = 32'h0040_0000, va = 32'hc07f_f123;
    logic [31:0] pte1 = 32'h8a40_0000 | 32'h0000_0153;  // present + large + attrs
    bit d, f;
    pt_mem[l1_addr(root, va)] = pte1;
    rsp_lat = 2; ready_gap = 1;
    issue(root, va);
    wait_end(d, f);
    chk("R4 done", {30'd0, d, f}, 32'd2);
    chk("R4 l1 addr", reads[0], l1_addr(root, va));
    chk("R4 one read", 32'(n_reads), 32'd1);
    chk("R4 large", 32'(res_large_o), 32'd1);
    chk("R4 ppn", 32'(res_ppn_o), 32'({pte1[31:22], va[21:12]}));
    chk("R4 pa", res_pa_o, {pte1[31:22], va[21:0]});
    chk("R10 attr large", 32'(res_attr_o), 32'(pte1[11:2]));
    @(negedge clk_i);
    chk("R10 done pulse", 32'(done_o), 32'd0);
    repeat (4) @(negedge clk_i);
    chk("R10 ppn held", 32'(res_ppn_o), 32'({pte1[31:22], va[21:12]}));
  endtask

  task automatic test_l1_fault();
    logic [31:0] root = 32'h0080_0000, va = 32'h7fc0_0abc;
    bit d, f;
    pt_mem[l1_addr(root, va)] = 32'hffff_fffe;  // not present
    rsp_lat = 5; ready_gap = 0;
    issue(root, va);
    wait_end(d, f);
    chk("R3 fault", {30'd0, d, f}, 32'd1);
    chk("R3 level", 32'(fault_level_o), 32'd0);
    chk("R3 one read", 32'(n_reads), 32'd1);
    @(negedge clk_i);
    chk("R10 fault pulse", 32'(fault_o), 32'd0);
    chk("R8 ready after fault", 32'(req_ready_o), 32'd1);
  endtask

  task automatic test_l2_fault();
    logic [31:0] root = 32'h0100_0000, va = 32'h0040_3000;
    logic [31:0] pte1 = 32'h0300_0005;
    bit d, f;
    pt_mem[l1_addr(root, va)] = pte1;
    pt_mem[l2_addr(pte1, va)] = 32'h1234_5000;  // not present
    rsp_lat = 7; ready_gap = 2;
    issue(root, va);
    wait_end(d, f);
    chk("R6 fault", {30'd0, d, f}, 32'd1);
    chk("R6 level", 32'(fault_level_o), 32'd1);
    chk("R9 l2 addr under stall", reads[1], l2_addr(pte1, va));
    chk("R6 reads", 32'(n_reads), 32'd2);
  endtask

  task automatic test_busy();
    logic [31:0] root = 32'h0200_0000, va = 32'h0123_4abc, vb = 32'hfedc_b000;
    logic [31:0] pte1 = 32'h0500_0001, pte2 = 32'h0777_7005;
    bit d, f;
    pt_mem[l1_addr(root, va)] = pte1;
    pt_mem[l2_addr(pte1, va)] = pte2;
    rsp_lat = 6; ready_gap = 0;
    issue(root, va);
    for (int i = 0; i < 4; i++) begin
      req_va_i    = vb;
      req_valid_i = 1'b1;
      @(negedge clk_i);
      chk("R8 busy", 32'(req_ready_o), 32'd0);
    end
    req_valid_i = 1'b0;
    wait_end(d, f);
    chk("R8 first served", res_pa_o, {pte2[31:12], va[11:0]});
    repeat (3) begin
      @(negedge clk_i);
      chk("R8 no extra walk", {30'd0, done_o, fault_o}, 32'd0);
    end
    chk("R9 two reads", 32'(n_reads), 32'd2);
    chk("R8 idle", 32'(req_ready_o), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    test_reset();
    test_small_page();
    test_large_page();
    test_l1_fault();
    test_l2_fault();
    test_busy();
    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule